// File: doc/BRIEF.md
# Serial Coefficient Row Loader

This block fills a small register file of filter coefficients from a serial bit stream. The stream runs on its own serial clock, with a data pin and an active-low enable. Each frame is 64 bits long, is sent most significant bit first, and is made of four 16-bit words. The frame carries a 5-bit row address and four 12-bit coefficients. When the last bit of a frame arrives, all four coefficients are written into the addressed row in a single write.

The serial logic starts only after it has seen the enable high on one clock edge and low on a later edge. Until then, incoming bits are ignored. The enable may stay low across any number of back-to-back frames, and each frame then loads its own row. If the enable goes high before a frame is complete, the partial frame is dropped and nothing is written.

A combinational read port returns the four coefficients of any row to the filter datapath.

Top module: `coef_loader`

## Requirements
- R1: While the loader is armed and `serEnN` is low, each rising edge of `sclk` shifts in one bit from `serData`. The first bit shifted is frame bit 63, the last is frame bit 0.
- R2: On an `sclk` edge where `serEnN` is high, no bit is shifted and no row of the register file changes.
- R3: The write to the register file happens on the edge that shifts frame bit 0, and is visible on the read port after that edge. After only 63 bits of a frame, the addressed row still holds its old value.
- R4: If `serEnN` is sampled high before a frame is complete, that partial frame writes nothing. The next frame starts its count from bit 63.
- R5: After reset, the loader ignores `serEnN` low until it has sampled `serEnN` high on an edge. The first low sample after that arms the loader and shifts the first bit.
- R6: With `serEnN` held low without a break, consecutive frames each write their own row.
- R7: Word k of the frame occupies frame bits [63-16k : 48-16k], for k = 0 to 3. The coefficient is the word's low 12 bits: word 0 carries coefficient 4, word 1 coefficient 3, word 2 coefficient 2 and word 3 coefficient 1. Row bits 4 to 1 are word 0 bits [15:12], and row bit 0 is word 1 bit 15. All other bits are don't-care and have no effect.
- R8: `rdCoef` shows the row selected by `rdRow` in the same cycle, packed as {coef4, coef3, coef2, coef1} with coefficient 1 in bits [11:0].
- R9: An active-low `rstN` clears every row to zero and disarms the loader.
- R10: A frame for row 2 with coefficients 1 to 4 equal to 0x7E4, 0x1A4, 0x08C and 0x7EC makes a read of row 2 return 0x7EC08C1A47E4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| serEnN | input | 1 | Active-low serial enable |
| serData | input | 1 | Serial data bit |
| rdRow | input | 5 | Row selected on the read port |
| rdCoef | output | 48 | Four coefficients of the selected row |

## Verification
The bench builds the block with its default parameters: four 12-bit coefficients in 16-bit words, which gives a 64-bit frame and 32 rows. These values let the bench reach both end rows, 0 and 31, and confirm that the 6-bit bit counter wraps cleanly between back-to-back frames. They also give room for don't-care fill of all ones or all zeros, an abort partway through a frame, and a read taken one edge before the final bit.

// File: rtl/coef_loader_pkg.sv
package coef_loader_pkg;
  typedef struct packed {
    logic shiftEn;
    logic writeEn;
  } loadStrobe_t;
endpackage

// File: rtl/coef_loader_ctrl.sv
module coef_loader_ctrl
  import coef_loader_pkg::*;
#(
  parameter int FRAME_W = 64
) (
  input  logic        sclk,
  input  logic        rstN,
  input  logic        serEnN,
  output loadStrobe_t stb
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic             sawHigh;
  logic             armed;
  logic [CNT_W-1:0] bitCnt;
  logic             active;

  assign active      = !serEnN && (armed || sawHigh);
  assign stb.shiftEn = active;
  assign stb.writeEn = active && (bitCnt == LAST);

  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN) begin
      sawHigh <= 1'b0;
      armed   <= 1'b0;
      bitCnt  <= '0;
    end else if (serEnN) begin
      sawHigh <= 1'b1;
      armed   <= 1'b0;
      bitCnt  <= '0;
    end else if (active) begin
      sawHigh <= 1'b0;
      armed   <= 1'b1;
      bitCnt  <= (bitCnt == LAST) ? '0 : bitCnt + 1'b1;
    end
  end
endmodule

// File: rtl/coef_loader_dp.sv
module coef_loader_dp
  import coef_loader_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int COEF_W   = 12,
  parameter int WORD_W   = 16,
  parameter int NUM_COEF = 4
) (
  input  logic                       sclk,
  input  logic                       rstN,
  input  logic                       serData,
  input  loadStrobe_t                stb,
  input  logic [ADDR_W-1:0]          rdRow,
  output logic [NUM_COEF*COEF_W-1:0] rdCoef
);
  localparam int FRAME_W = NUM_COEF * WORD_W;
  localparam int HDR_W   = WORD_W - COEF_W;
  localparam int ROWS    = 1 << ADDR_W;
  localparam int ROW_W   = NUM_COEF * COEF_W;

  logic [FRAME_W-2:0] shiftReg;
  logic [ROW_W-1:0]   wrData;
  logic [ADDR_W-1:0]  wrRow;
  logic [ROW_W-1:0]   mem [ROWS];

  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (stb.shiftEn) shiftReg <= {shiftReg[FRAME_W-3:0], serData};
  end

  // frame bit p is shiftReg[p-1] for p >= 1 and serData for p == 0
  for (genvar k = 0; k < NUM_COEF; k++) begin : gWord
    localparam int TOP = FRAME_W - 1 - k * WORD_W - HDR_W;
    localparam int SLOT = NUM_COEF - 1 - k;
    if (TOP - COEF_W + 1 == 0) begin : gLast
      assign wrData[SLOT*COEF_W +: COEF_W] = {shiftReg[COEF_W-2:0], serData};
    end else begin : gMid
      assign wrData[SLOT*COEF_W +: COEF_W] = shiftReg[TOP-1 -: COEF_W];
    end
  end

  for (genvar j = 0; j < ADDR_W; j++) begin : gRow
    localparam int POS = FRAME_W - 1 - (j / HDR_W) * WORD_W - (j % HDR_W);
    assign wrRow[ADDR_W-1-j] = shiftReg[POS-1];
  end

  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < ROWS; r++) mem[r] <= '0;
    end else if (stb.writeEn) begin
      mem[wrRow] <= wrData;
    end
  end

  assign rdCoef = mem[rdRow];
endmodule

// File: rtl/coef_loader.sv
module coef_loader
  import coef_loader_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int COEF_W   = 12,
  parameter int WORD_W   = 16,
  parameter int NUM_COEF = 4
) (
  input  logic                       sclk,
  input  logic                       rstN,
  input  logic                       serEnN,
  input  logic                       serData,
  input  logic [ADDR_W-1:0]          rdRow,
  output logic [NUM_COEF*COEF_W-1:0] rdCoef
);
  localparam int FRAME_W = NUM_COEF * WORD_W;

  loadStrobe_t stb;

  coef_loader_ctrl #(.FRAME_W(FRAME_W)) uCtrl (
    .sclk(sclk), .rstN(rstN), .serEnN(serEnN), .stb(stb)
  );

  coef_loader_dp #(
    .ADDR_W(ADDR_W), .COEF_W(COEF_W), .WORD_W(WORD_W), .NUM_COEF(NUM_COEF)
  ) uDp (
    .sclk(sclk), .rstN(rstN), .serData(serData), .stb(stb),
    .rdRow(rdRow), .rdCoef(rdCoef)
  );
endmodule

// File: rtl/coef_loader_chk.sv
module coef_loader_chk #(
  parameter int ADDR_W   = 5,
  parameter int COEF_W   = 12,
  parameter int WORD_W   = 16,
  parameter int NUM_COEF = 4
) (
  input logic                       sclk,
  input logic                       rstN,
  input logic                       serEnN,
  input logic [ADDR_W-1:0]          rdRow,
  input logic [NUM_COEF*COEF_W-1:0] rdCoef,
  input logic                       wrEn
);
  localparam int FRAME_W = NUM_COEF * WORD_W;
  localparam int CW = $clog2(FRAME_W) + 1;

  logic          hiSeen;
  logic          running;
  logic [CW-1:0] bitsIn;
  logic          lowOk;

  assign lowOk = !serEnN && (running || hiSeen);

  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN) begin
      hiSeen <= 1'b0; running <= 1'b0; bitsIn <= '0;
    end else if (serEnN) begin
      hiSeen <= 1'b1; running <= 1'b0; bitsIn <= '0;
    end else if (lowOk) begin
      hiSeen <= 1'b0; running <= 1'b1;
      bitsIn <= (bitsIn == CW'(FRAME_W - 1)) ? '0 : bitsIn + 1'b1;
    end
  end

  // R3: a write only on the edge that takes in the final frame bit
  a_r3_write_on_last_bit: assert property (@(posedge sclk) disable iff (!rstN)
    wrEn |-> (lowOk && bitsIn == CW'(FRAME_W - 1)));

  // R5: no write before the loader is armed
  a_r5_silent_until_armed: assert property (@(posedge sclk) disable iff (!rstN)
    (!serEnN && !running && !hiSeen) |-> !wrEn);

  // R4: enable high never writes
  a_r4_no_write_when_high: assert property (@(posedge sclk) disable iff (!rstN)
    serEnN |-> !wrEn);

  // R2: contents hold across an edge with enable high
  a_r2_hold_when_high: assert property (@(posedge sclk) disable iff (!rstN)
    ($past(serEnN) && $stable(rdRow)) |-> $stable(rdCoef));

  // R6: frames never write on adjacent edges
  a_r6_frame_spacing: assert property (@(posedge sclk) disable iff (!rstN)
    wrEn |=> !wrEn);
endmodule

bind coef_loader coef_loader_chk #(
  .ADDR_W(ADDR_W), .COEF_W(COEF_W), .WORD_W(WORD_W), .NUM_COEF(NUM_COEF)
) uChk (
  .sclk(sclk), .rstN(rstN), .serEnN(serEnN), .rdRow(rdRow),
  .rdCoef(rdCoef), .wrEn(stb.writeEn)
);

// File: tb/tb_coef_loader.sv
`timescale 1ns/1ps
module tb_coef_loader;
  localparam int ADDR_W = 5;
  localparam int COEF_W = 12;
  localparam int ROW_W  = 48;

  logic              sclk = 1'b0;
  logic              rstN = 1'b0;
  logic              serEnN = 1'b0;
  logic              serData = 1'b0;
  logic [ADDR_W-1:0] rdRow = '0;
  logic [ROW_W-1:0]  rdCoef;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 sclk = ~sclk;

  coef_loader dut (
    .sclk(sclk), .rstN(rstN), .serEnN(serEnN), .serData(serData),
    .rdRow(rdRow), .rdCoef(rdCoef)
  );

  // vector: {row, c1, c2, c3, c4, dcFill}
  localparam int VW = ADDR_W + 4 * COEF_W + 1;
  localparam logic [VW-1:0] VEC [4] = '{
    {5'd2,  12'h7E4, 12'h1A4, 12'h08C, 12'h7EC, 1'b0},
    {5'd31, 12'hFFF, 12'h001, 12'h800, 12'h5A5, 1'b1},
    {5'd0,  12'h123, 12'h456, 12'h789, 12'hABC, 1'b1},
    {5'd17, 12'h0F0, 12'hF0F, 12'h3C3, 12'hC3C, 1'b0}
  };

  function automatic logic [63:0] mkFrame(input logic [4:0] row,
      input logic [11:0] c1, c2, c3, c4, input logic dc);
    logic [15:0] w0, w1, w2, w3;
    w0 = {row[4:1], c4};
    w1 = {row[0], {3{dc}}, c3};
    w2 = {{4{dc}}, c2};
    w3 = {{4{dc}}, c1};
    return {w0, w1, w2, w3};
  endfunction

  task automatic shiftBits(input logic [63:0] f, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge sclk);
      serEnN = 1'b0;
      serData = f[63-i];
    end
  endtask

  task automatic arm();
    @(negedge sclk);
    serEnN = 1'b1;
    serData = 1'b1;
  endtask

  task automatic checkRow(input logic [4:0] row, input logic [ROW_W-1:0] exp,
      input string tag);
    rdRow = row;
    #0.5;
    checks++;
    if (rdCoef !== exp) begin
      errors++;
      $display("FAIL %s row %0d: got %h expected %h", tag, row, rdCoef, exp);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] f;
    logic [ROW_W-1:0] e;
    repeat (3) @(negedge sclk);
    // R9: reset state
    checkRow(5'd0, '0, "R9");
    checkRow(5'd2, '0, "R9");
    checkRow(5'd31, '0, "R9");
    rstN = 1'b1;

    // R5: enable low since reset, never seen high: frame ignored
    shiftBits(mkFrame(5'd3, 12'h111, 12'h222, 12'h333, 12'h444, 1'b0), 64);
    @(negedge sclk);
    checkRow(5'd3, '0, "R5");

    // R1 R3 R7 R8 R10: table walk
    for (int v = 0; v < 4; v++) begin
      logic [VW-1:0] t;
      t = VEC[v];
      f = mkFrame(t[VW-1 -: 5], t[48:37], t[36:25], t[24:13], t[12:1], t[0]);
      e = {t[12:1], t[24:13], t[36:25], t[48:37]};
      arm();
      if (v == 0) begin
        // R3: after 63 bits the row is not yet written
        shiftBits(f, 63);
        @(negedge sclk);
        serData = f[0];
        checkRow(5'd2, '0, "R3");
        @(negedge sclk);
        serEnN = 1'b1;
        checkRow(5'd2, 48'h7EC08C1A47E4, "R10");
      end else begin
        shiftBits(f, 64);
        @(negedge sclk);
        serEnN = 1'b1;
        checkRow(t[VW-1 -: 5], e, "R7");
      end
    end

    // R6: back-to-back frames with enable held low
    arm();
    shiftBits(mkFrame(5'd5, 12'hA01, 12'hA02, 12'hA03, 12'hA04, 1'b1), 64);
    shiftBits(mkFrame(5'd6, 12'hB01, 12'hB02, 12'hB03, 12'hB04, 1'b0), 64);
    @(negedge sclk);
    serEnN = 1'b1;
    checkRow(5'd5, 48'hA04A03A02A01, "R6");
    checkRow(5'd6, 48'hB04B03B02B01, "R6");

    // R4: abort partway, then a full frame
    arm();
    shiftBits(mkFrame(5'd7, 12'hC01, 12'hC02, 12'hC03, 12'hC04, 1'b0), 30);
    arm();
    shiftBits(mkFrame(5'd8, 12'hD01, 12'hD02, 12'hD03, 12'hD04, 1'b0), 64);
    @(negedge sclk);
    serEnN = 1'b1;
    checkRow(5'd7, '0, "R4");
    checkRow(5'd8, 48'hD04D03D02D01, "R4");

    // R2: enable high with toggling data changes nothing
    for (int i = 0; i < 70; i++) begin
      @(negedge sclk);
      serEnN = 1'b1;
      serData = i[0];
    end
    checkRow(5'd2, 48'h7EC08C1A47E4, "R2");
    checkRow(5'd8, 48'hD04D03D02D01, "R2");

    // R9: reset clears a written row
    rstN = 1'b0;
    #0.5;
    checkRow(5'd31, '0, "R9");
    rstN = 1'b1;

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule